// File: doc/BRIEF.md
# PCM Voice Serial Port (Short Frame Sync)

This block is the digital serial side of a telephony PCM codec. Each 8 kHz frame moves one voice sample in each direction. On the transmit side, a frame sync pulse one bit period wide is sampled on a falling bit-clock edge. The block then captures the parallel code that the encoder finished in the previous cycle and tells the encoder to start a new conversion. It shifts the code out MSB first on a data pin that is enabled only for the duration of the slot. An active-low, open-drain style time-slot indicator is low while that pin is driven.

On the receive side, a second frame sync pulse arms a capture. The following eight falling bit-clock edges latch serial bits MSB first. The assembled byte is then presented to the decoder together with a one-cycle valid strobe.

The bit clock, both frame syncs and the receive data are oversampled by the system clock `clk_i`, through a parameterised synchroniser. Edges of the bit clock are detected synchronously, so every register in the block lives in one clock domain. The tri-state pin is modelled as a data bit plus an output-enable.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, `tx_oe_o` is 0, `slot_n_o` is 1, `rx_valid_o` is 0 and `enc_start_o` is 0.
- R2: When `tx_sync_i` is high at a falling bit-clock edge, the next rising edge sets `tx_oe_o` to 1 and drives bit 7 (the sign bit) of the captured code on `tx_data_o`.
- R3: Each of the seven rising edges after the sign bit drives the next lower bit (bit 6 down to bit 0). `tx_data_o` changes only on rising bit-clock edges.
- R4: The first falling bit-clock edge after bit 0 has been driven returns `tx_oe_o` to 0.
- R5: The transmitted byte equals `enc_code_i` as sampled at the falling edge where `tx_sync_i` was high. That same edge produces exactly one single-cycle pulse on `enc_start_o`.
- R6: `slot_n_o` is 0 exactly while `tx_oe_o` is 1, and 1 otherwise.
- R7: When `rx_sync_i` is high at a falling edge, the next eight falling edges latch `rx_data_i` as bits 7 down to 0. After the eighth, `rx_code_o` holds the byte and `rx_valid_o` pulses for one clock cycle; there is no pulse before then.
- R8: A transmit frame sync seen while a slot is in progress restarts the slot. The next rising edge drives bit 7 of the newly captured code, and eight full bits follow.
- R9: A receive frame sync seen while a capture is in progress discards the partial byte. Only the byte assembled from the eight falls after the new sync is delivered, with a single valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| tx_sync_i | input | 1 | Transmit frame sync, one bit period wide |
| enc_code_i | input | PCM_W | Code from the previous encode cycle |
| enc_start_o | output | 1 | One-cycle pulse starting a new encode cycle |
| tx_data_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Output enable for the transmit data pin |
| slot_n_o | output | 1 | Active-low transmit time-slot indicator |
| rx_sync_i | input | 1 | Receive frame sync, one bit period wide |
| rx_data_i | input | 1 | Serial receive data |
| rx_code_o | output | PCM_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_code_o` is updated |

## Verification
The bench builds the block with `PCM_W` = 8 and `SYNC_STAGES` = 2, and with a bit clock of 16 system-clock cycles per period. This leaves several cycles of margin beyond the synchroniser and edge-detect latency before each sample. With an 8-bit word, every one of the 256 codes can be sent in both directions in one run. A transmit and a receive frame sync are each injected in the middle of a slot, which brings the restart paths and the release/arm overlap within reach. Idle periods without sync confirm that the pin stays released between frames.

// File: rtl/pcm_sp_pkg.sv
package pcm_sp_pkg;

  typedef struct packed {
    logic bclk;
    logic tx_sync;
    logic rx_sync;
    logic rx_data;
  } pcm_pins_t;

  function automatic int unsigned cnt_w(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync
  import pcm_sp_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pcm_pins_t d_i,
  output pcm_pins_t q_o
);

  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_sync
    pcm_pins_t stg_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
      end else begin
        stg_q[0] <= d_i;
        for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
      end
    end

    assign q_o = stg_q[STAGES-1];
  end

endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
  import pcm_sp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         sync_i,
  input  logic [W-1:0] code_i,
  output logic         data_o,
  output logic         oe_o,
  output logic         slot_n_o,
  output logic         start_o
);

  localparam int unsigned CW = cnt_w(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q, oe_q, data_q, slot_q, start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
      data_q  <= 1'b0;
      slot_q  <= 1'b1;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (fall_i) begin
        // release after the last bit has been on the pin
        if (oe_q && !armed_q && cnt_q == LAST) begin
          oe_q   <= 1'b0;
          slot_q <= 1'b1;
        end
        if (sync_i) begin
          armed_q <= 1'b1;
          sh_q    <= code_i;
          start_q <= 1'b1;
        end
      end else if (rise_i) begin
        if (armed_q) begin
          armed_q <= 1'b0;
          oe_q    <= 1'b1;
          slot_q  <= 1'b0;
          data_q  <= sh_q[W-1];
          sh_q    <= sh_q << 1;
          cnt_q   <= '0;
        end else if (oe_q && cnt_q != LAST) begin
          data_q <= sh_q[W-1];
          sh_q   <= sh_q << 1;
          cnt_q  <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign data_o   = data_q;
  assign oe_o     = oe_q;
  assign slot_n_o = slot_q;
  assign start_o  = start_q;

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
  import pcm_sp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_i,
  input  logic         sync_i,
  input  logic         bit_i,
  output logic [W-1:0] code_o,
  output logic         valid_o
);

  localparam int unsigned CW = cnt_w(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q, code_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q, active_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      code_q   <= '0;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (fall_i) begin
        if (sync_i) begin
          // new frame wins over any partial capture
          armed_q  <= 1'b1;
          active_q <= 1'b0;
        end else if (armed_q) begin
          armed_q  <= 1'b0;
          active_q <= 1'b1;
          sh_q     <= {sh_q[W-2:0], bit_i};
          cnt_q    <= CW'(1);
        end else if (active_q) begin
          sh_q <= {sh_q[W-2:0], bit_i};
          if (cnt_q == LAST) begin
            code_q   <= {sh_q[W-2:0], bit_i};
            valid_q  <= 1'b1;
            active_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      end
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_sp_pkg::*;
#(
  parameter int unsigned PCM_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             tx_sync_i,
  input  logic [PCM_W-1:0] enc_code_i,
  output logic             enc_start_o,
  output logic             tx_data_o,
  output logic             tx_oe_o,
  output logic             slot_n_o,
  input  logic             rx_sync_i,
  input  logic             rx_data_i,
  output logic [PCM_W-1:0] rx_code_o,
  output logic             rx_valid_o
);

  pcm_pins_t pins_raw, pins_s;
  logic      bclk_q, bclk_rise, bclk_fall;

  assign pins_raw = '{bclk: bclk_i, tx_sync: tx_sync_i,
                      rx_sync: rx_sync_i, rx_data: rx_data_i};

  pcm_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= pins_s.bclk;
  end

  assign bclk_rise = pins_s.bclk & ~bclk_q;
  assign bclk_fall = ~pins_s.bclk & bclk_q;

  pcm_tx_slot #(.W(PCM_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (bclk_rise),
    .fall_i   (bclk_fall),
    .sync_i   (pins_s.tx_sync),
    .code_i   (enc_code_i),
    .data_o   (tx_data_o),
    .oe_o     (tx_oe_o),
    .slot_n_o (slot_n_o),
    .start_o  (enc_start_o)
  );

  pcm_rx_slot #(.W(PCM_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (bclk_fall),
    .sync_i  (pins_s.rx_sync),
    .bit_i   (pins_s.rx_data),
    .code_o  (rx_code_o),
    .valid_o (rx_valid_o)
  );

endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rise_i,
  input logic fall_i,
  input logic tx_oe_i,
  input logic tx_data_i,
  input logic slot_n_i,
  input logic start_i,
  input logic rx_valid_i
);

  AST_OE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_oe_i) |-> $past(rise_i)); // R2

  AST_DATA_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_data_i) |-> $past(rise_i)); // R3

  AST_RELEASE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_oe_i) |-> $past(fall_i)); // R4

  AST_START_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> $past(fall_i)); // R5

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !start_i); // R5

  AST_SLOT_TRACKS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_n_i == !tx_oe_i); // R6

  AST_VALID_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> $past(fall_i)); // R7

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i); // R7

endmodule

bind pcm_serial_port pcm_serial_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rise_i     (bclk_rise),
  .fall_i     (bclk_fall),
  .tx_oe_i    (tx_oe_o),
  .tx_data_i  (tx_data_o),
  .slot_n_i   (slot_n_o),
  .start_i    (enc_start_o),
  .rx_valid_i (rx_valid_o)
);

// File: tb/sim_pcm_serial_port.sv
module sim_pcm_serial_port;

  localparam int W = 8;
  localparam int H = 8;  // system clocks per bit-clock half period

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bclk = 1'b0, tx_sync = 1'b0, rx_sync = 1'b0, rx_bit = 1'b0;
  logic [W-1:0] enc_code = '0;
  logic         enc_start, tx_data, tx_oe, slot_n, rx_valid;
  logic [W-1:0] rx_code;

  int checks = 0, errors = 0;
  int vcount = 0, scount = 0;
  logic [W-1:0] vcode = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcm_serial_port #(.PCM_W(W), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .tx_sync_i(tx_sync),
    .enc_code_i(enc_code), .enc_start_o(enc_start), .tx_data_o(tx_data),
    .tx_oe_o(tx_oe), .slot_n_o(slot_n), .rx_sync_i(rx_sync),
    .rx_data_i(rx_bit), .rx_code_o(rx_code), .rx_valid_o(rx_valid)
  );

  always @(posedge clk) begin
    if (rx_valid) begin vcount++; vcode = rx_code; end
    if (enc_start) scount++;
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_tx(input string tag, input logic eoe, input logic ed);
    chk({tag, " oe"}, W'(tx_oe), W'(eoe));
    chk("R6 slot_n", W'(slot_n), W'(!eoe));
    if (eoe) chk({tag, " data"}, W'(tx_data), W'(ed));
  endtask

  // one bit period: rise (drive inputs), sample, fall, sample
  task automatic period(input logic ts, input logic rs, input logic rb,
                        input logic oe_hi, input logic d_hi, input logic oe_lo,
                        input string tag);
    bclk = 1'b1; tx_sync = ts; rx_sync = rs; rx_bit = rb;
    repeat (H) @(negedge clk);
    chk_tx(tag, oe_hi, d_hi);
    bclk = 1'b0;
    repeat (H) @(negedge clk);
    chk_tx(tag, oe_lo, d_hi);
  endtask

  task automatic frame(input logic [W-1:0] tc, input logic [W-1:0] rc);
    int v0, s0;
    v0 = vcount; s0 = scount;
    enc_code = tc;
    period(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 idle");
    chk("R5 start", W'(scount - s0), W'(1));
    for (int k = 1; k <= W; k++) begin
      period(1'b0, 1'b0, rc[W-k], 1'b1, tc[W-k], k < W,
             k == 1 ? "R2" : (k == W ? "R4" : "R3"));
      if (k == W - 1) chk("R7 early", W'(vcount - v0), W'(0));
    end
    chk("R7 count", W'(vcount - v0), W'(1));
    chk("R7 code", vcode, rc);
    chk("R5 code once", W'(scount - s0), W'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe", W'(tx_oe), W'(0));
    chk("R1 slot_n", W'(slot_n), W'(1));
    chk("R1 valid", W'(rx_valid), W'(0));
    chk("R1 start", W'(enc_start), W'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    period(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 idle");

    for (int c = 0; c < 256; c++) begin
      frame(W'(c), W'(c * 37 + 11));
      if (c % 16 == 15) period(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 gap");
    end

    // restart mid-slot: code A for 3 bits, new sync in period 3 with code B
    begin
      logic [W-1:0] a, b, ra, rb2;
      int v0;
      a = 8'hC3; b = 8'h5A; ra = 8'hFF; rb2 = 8'h96;
      v0 = vcount;
      enc_code = a;
      period(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 idle");
      period(1'b0, 1'b0, ra[7], 1'b1, a[7], 1'b1, "R8 a7");
      period(1'b0, 1'b0, ra[6], 1'b1, a[6], 1'b1, "R8 a6");
      enc_code = b;
      period(1'b1, 1'b1, ra[5], 1'b1, a[5], 1'b1, "R8 a5");
      for (int k = 1; k <= W; k++)
        period(1'b0, 1'b0, rb2[W-k], 1'b1, b[W-k], k < W, "R8 restart");
      chk("R9 count", W'(vcount - v0), W'(1));
      chk("R9 code", vcode, rb2);
    end
    period(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 tail");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule